// File: doc/BRIEF.md
# Region Attribute Priority Matcher

This block decides the effective access attributes of every memory reference. A reference arrives on a single access port, which the processor core and the debug port share, so both are resolved by exactly the same rule. The upper eight address bits are compared against two programmable address windows. Each window holds a base, an ignore mask and an enable. The first window that hits, in fixed priority with window 0 first, supplies the attribute set. When no window hits, a default attribute set is used. The default is held in a register of the cache control block.

Each attribute set has three flags. The first marks the reference cacheable. The second selects imprecise rather than precise handling of operand writes. The third makes the target write-protected. Resolution is combinational, so the attributes belong to the address presented in the same cycle. A valid write that lands on a write-protected attribute raises a fault in that cycle and is not forwarded. The windows and the default are loaded through a small synchronous write port.

Top module: `rattr_matcher`

## Requirements
- R1: After reset both windows are disabled and the default set is all zero (noncacheable, precise, unprotected). Any access then yields attributes 000 and grant 00.
- R2: Window k hits when its enable is 1 and, for every bit i in 0..7, either ignore[i]=1 or acc_addr[24+i]=base[i]. Address bits 23:0 never affect the result.
- R3: A disabled window never hits, whatever its base and mask.
- R4: When window 0 hits, its attributes are output and grant=01, even if window 1 also hits.
- R5: When window 0 misses and window 1 hits, window 1's attributes are output and grant=10.
- R6: When neither window hits, the default attributes are output and grant=00.
- R7: Attributes, grant, fault and forward depend only on the current address and access inputs and the stored configuration. They change in the same cycle as the address, with no register on the path.
- R8: Consider an access with acc_valid=1 and acc_write=1. If its resolved write-protect flag is 1, prot_fault=1 and wr_fwd=0. If the flag is 0, wr_fwd=1 and prot_fault=0. When acc_valid=0 or acc_write=0, both outputs are 0.
- R9: Configuration is written on a rising clock edge when cfg_we=1, and it takes effect from that edge. The cfg_wdata layout is [7:0] base, [15:8] ignore mask, [16] enable, [17] cacheable, [18] imprecise and [19] write-protect. cfg_sel=0 loads window 0 and cfg_sel=1 loads window 1. cfg_sel=2 loads only bits [19:17] into the default set. cfg_sel=3 changes nothing, and no state changes when cfg_we=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 window 0, 1 window 1, 2 default set |
| cfg_wdata | input | 20 | Configuration word, layout as in R9 |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| attr_cacheable | output | 1 | Effective cacheable flag |
| attr_imprecise | output | 1 | Effective imprecise-write flag |
| attr_wprot | output | 1 | Effective write-protect flag |
| grant | output | 2 | One-hot window that supplied the attributes, 0 for default |
| prot_fault | output | 1 | Write to protected target |
| wr_fwd | output | 1 | Write allowed to proceed |

## Verification
All access-side results are combinational. The bench therefore drives the address on the falling edge and samples about 2 ns later, within the same cycle, with no clock edge in between. A configuration write is driven on a falling edge and lands on the following rising edge. The bench checks its effect only from the next falling edge onward, and then sweeps all 256 values of the address tag. In each sweep the low address bits are random and the read/write mix is varied.

// File: rtl/rattr_pkg.sv
package rattr_pkg;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic wprot;
    logic imprecise;
    logic cacheable;
  } attr_t;

  typedef struct packed {
    logic             en;
    logic [TAG_W-1:0] ignore;
    logic [TAG_W-1:0] base;
  } win_t;

  localparam int ATTR_W = $bits(attr_t);
  localparam int WIN_W  = $bits(win_t);
  localparam int CFG_W  = WIN_W + ATTR_W;

  // masked compare: every bit not ignored must equal the base
  function automatic logic tag_hit(input win_t w, input logic [TAG_W-1:0] tag);
    return w.en & (((tag ^ w.base) & ~w.ignore) == '0);
  endfunction
endpackage

// File: rtl/rattr_cfg.sv
module rattr_cfg
  import rattr_pkg::*;
#(
  parameter int NWIN  = 2,
  parameter int SEL_W = $clog2(NWIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [CFG_W-1:0]      wdata,
  output win_t  [NWIN-1:0]      win,
  output attr_t [NWIN-1:0]      wattr,
  output attr_t                 dflt
);
  localparam logic [SEL_W-1:0] DFLT_SEL = SEL_W'(NWIN);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[g]   <= '0;
        wattr[g] <= '0;
      end else if (we && sel == MY_SEL) begin
        win[g]   <= wdata[WIN_W-1:0];
        wattr[g] <= wdata[CFG_W-1:WIN_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dflt <= '0;
    else if (we && sel == DFLT_SEL)   dflt <= wdata[CFG_W-1:WIN_W];
  end

  // R9: without a write strobe nothing stored may move
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(win) && $stable(wattr) && $stable(dflt)));
endmodule

// File: rtl/rattr_cmp.sv
module rattr_cmp
  import rattr_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic [TAG_W-1:0]  tag,
  input  win_t [NWIN-1:0]   win,
  output logic [NWIN-1:0]   hit
);
  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign hit[g] = tag_hit(win[g], tag);
  end
endmodule

// File: rtl/rattr_sel.sv
module rattr_sel
  import rattr_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic  [NWIN-1:0]  hit,
  input  attr_t [NWIN-1:0]  wattr,
  input  attr_t             dflt,
  output attr_t             eff,
  output logic  [NWIN-1:0]  grant
);
  // lowest index wins; scan from the top so lower indices overwrite
  always_comb begin
    eff   = dflt;
    grant = '0;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (hit[k]) begin
        eff   = wattr[k];
        grant = NWIN'(1) << k;
      end
    end
  end
endmodule

// File: rtl/rattr_matcher.sv
module rattr_matcher
  import rattr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NWIN+1)-1:0]   cfg_sel,
  input  logic [rattr_pkg::CFG_W-1:0] cfg_wdata,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic [ADDR_W-1:0]           acc_addr,
  output logic                        attr_cacheable,
  output logic                        attr_imprecise,
  output logic                        attr_wprot,
  output logic [NWIN-1:0]             grant,
  output logic                        prot_fault,
  output logic                        wr_fwd
);
  localparam int LO_W = ADDR_W - TAG_W;

  win_t  [NWIN-1:0] win;
  attr_t [NWIN-1:0] wattr;
  attr_t            dflt;
  attr_t            eff;
  logic  [NWIN-1:0] hit;
  logic [TAG_W-1:0] tag;
  logic             wr_req;
  logic             unused_lo;

  assign tag       = acc_addr[ADDR_W-1:LO_W];
  assign unused_lo = ^acc_addr[LO_W-1:0];

  rattr_cfg #(.NWIN(NWIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .win(win), .wattr(wattr), .dflt(dflt)
  );

  rattr_cmp #(.NWIN(NWIN)) u_cmp (.tag(tag), .win(win), .hit(hit));

  rattr_sel #(.NWIN(NWIN)) u_sel (
    .hit(hit), .wattr(wattr), .dflt(dflt), .eff(eff), .grant(grant)
  );

  assign attr_cacheable = eff.cacheable;
  assign attr_imprecise = eff.imprecise;
  assign attr_wprot     = eff.wprot;

  assign wr_req     = acc_valid & acc_write;
  assign prot_fault = wr_req & eff.wprot;
  assign wr_fwd     = wr_req & ~eff.wprot;

  assert_win0_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> (grant[0] && eff == wattr[0]));
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_win1_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit[0] && hit[1]) |-> (grant[1] && eff == wattr[1]));
  assert_default_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (grant == '0 && eff == dflt));
  assert_fault_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (acc_valid && acc_write && !wr_fwd && attr_wprot));
endmodule

// File: tb/tb_rattr_matcher.sv
module tb_rattr_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        attr_cacheable, attr_imprecise, attr_wprot, prot_fault, wr_fwd;
  logic [1:0]  grant;

  int total = 0;
  int bad = 0;

  // bench copy of the configuration, as the requirements describe it
  logic [7:0] m_base [2];
  logic [7:0] m_ign  [2];
  logic       m_en   [2];
  logic [2:0] m_attr [2];
  logic [2:0] m_dflt;

  always #4 clk = ~clk;

  rattr_matcher dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .attr_cacheable(attr_cacheable),
    .attr_imprecise(attr_imprecise), .attr_wprot(attr_wprot), .grant(grant),
    .prot_fault(prot_fault), .wr_fwd(wr_fwd)
  );

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit win_hits(int k, logic [7:0] t);
    if (!m_en[k]) return 1'b0;
    for (int i = 0; i < 8; i++)
      if (!m_ign[k][i] && (t[i] != m_base[k][i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h addr=%h", req, got, exp, acc_addr);
    end
  endtask

  task automatic cfg_write(int sel, logic [7:0] base, logic [7:0] ign, bit en, logic [2:0] at);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = {at, en, ign, base};
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 2) begin
      m_base[sel] = base; m_ign[sel] = ign; m_en[sel] = en; m_attr[sel] = at;
    end else if (sel == 2) m_dflt = at;
  endtask

  // full tag sweep; req labels the requirement the pass exercises
  task automatic sweep(string req);
    for (int t = 0; t < 256; t++) begin
      logic h0, h1, ex_f, ex_w;
      logic [2:0] ex_at;
      logic [1:0] ex_g;
      @(negedge clk);
      acc_addr  = {8'(t), 24'($urandom)};
      acc_valid = (t % 5) != 0;
      acc_write = (t % 3) != 0;
      h0 = win_hits(0, 8'(t));
      h1 = win_hits(1, 8'(t));
      if (h0)      begin ex_at = m_attr[0]; ex_g = 2'b01; end
      else if (h1) begin ex_at = m_attr[1]; ex_g = 2'b10; end
      else         begin ex_at = m_dflt;    ex_g = 2'b00; end
      ex_f = acc_valid && acc_write && ex_at[2];
      ex_w = acc_valid && acc_write && !ex_at[2];
      #2;
      check({req, " R2 R7 attr"}, {5'b0, attr_wprot, attr_imprecise, attr_cacheable}, {5'b0, ex_at});
      check({req, " R4 R5 R6 grant"}, {6'b0, grant}, {6'b0, ex_g});
      check({req, " R8 fault/fwd"}, {6'b0, prot_fault, wr_fwd}, {6'b0, ex_f, ex_w});
    end
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_base[k] = '0; m_ign[k] = '0; m_en[k] = 1'b0; m_attr[k] = '0;
    end
    m_dflt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset");

    // overlapping windows: 0x10..0x1F via window 0, 0x1X and 0x3X via window 1
    cfg_write(0, 8'h12, 8'h0F, 1'b1, 3'b101);
    cfg_write(1, 8'h10, 8'h2F, 1'b1, 3'b110);
    cfg_write(2, 8'h00, 8'h00, 1'b0, 3'b011);
    sweep("R4 overlap");

    // scattered mask bits, window 1 alone in some places
    cfg_write(0, 8'hA5, 8'h81, 1'b1, 3'b001);
    cfg_write(1, 8'h05, 8'hF0, 1'b1, 3'b100);
    sweep("R5 scattered");

    // disabled window with all-ignore mask must not hit anywhere
    cfg_write(0, 8'h00, 8'hFF, 1'b0, 3'b111);
    sweep("R3 disabled");

    // select 3 is not a target: nothing may change
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = {3'b111, 1'b1, 8'hFF, 8'h00};
    @(negedge clk);
    cfg_we = 1'b0;
    sweep("R9 sel3");

    // data presented without strobe changes nothing
    @(negedge clk);
    cfg_sel = 2'd1; cfg_wdata = {3'b000, 1'b0, 8'h00, 8'h00};
    @(negedge clk);
    sweep("R9 nowe");

    // exact match, default protected; R6 default path under writes
    cfg_write(1, 8'h7E, 8'h00, 1'b1, 3'b010);
    cfg_write(2, 8'hFF, 8'hFF, 1'b1, 3'b100);
    sweep("R6 exact");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule